// File: doc/BRIEF.md
# Transport Stream Slice Reassembler

This block receives 32-bit capture words, one per valid strobe, and rebuilds 188-byte transport stream packets from them. Each word carries a 3-bit channel tag, a 3-bit rolling sequence count, a packet-start flag, a device overflow flag and a 24-bit payload slice. The block sorts the words into four independent channels and keeps a slice position for each one. It then emits the payload as a byte stream with the channel index and markers for the first and last byte of each packet.

A packet spans 63 slices. The last slice contributes only its two upper bytes (62×3+2 = 188). For each channel the block checks the sequence count and raises a one-cycle pulse when a count is skipped. It also raises a one-cycle pulse when a word reports an overflow in the capture device. The byte output uses a valid/ready handshake. A single holding register absorbs one slice, and while that slice drains the input is back-pressured.

Top module: `ts_slice_reassembler`

## Requirements
- R1: The tag in bits 31:29 selects the channel: tag value t in 1..4 maps to channel t-1. A word with tag 0, 5, 6 or 7 is dropped. It emits no byte and raises no pulse.
- R2: A word with bit 25 set starts a packet at slice 0, even when its channel is part way through a packet. The abandoned bytes stay as emitted, and the new packet begins with a fresh start marker.
- R3: A word with bit 25 clear is dropped, with no bytes emitted, while its channel has no packet in progress (slice position 0).
- R4: Payload bytes of a slice leave most significant byte first: bits 23:16, then 15:8, then 7:0.
- R5: A packet is 63 slices. Slice 62 emits only bits 23:16 and 15:8, so a packet is exactly 188 bytes. After slice 62 the channel returns to the idle position.
- R6: out_sop is high only with the first byte of slice 0, and out_eop is high only with the 188th byte.
- R7: The sequence count sits in bits 28:26. When a tag-valid word's count differs from its channel's previous count plus one (modulo 8), loss_pulse for that channel is high in the cycle after acceptance. The count is recorded for every tag-valid word, including words dropped under R3.
- R8: The first tag-valid word of each channel after reset is not checked for sequence loss.
- R9: A tag-valid word with bit 24 set raises ovf_pulse for its channel in the cycle after acceptance.
- R10: While out_valid is high and out_ready is low, the byte, channel and markers hold steady. in_ready is low whenever a slice is held.
- R11: Each channel keeps its own slice position, so packets of different channels can be interleaved slice by slice and each still comes out whole.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Capture word present |
| in_ready | output | 1 | Block can take a word |
| in_word | input | 32 | Capture word |
| out_valid | output | 1 | Output byte present |
| out_ready | input | 1 | Downstream takes the byte |
| out_chan | output | 2 | Channel of the output byte |
| out_byte | output | 8 | Output byte |
| out_sop | output | 1 | First byte of a packet |
| out_eop | output | 1 | Last byte of a packet |
| loss_pulse | output | 4 | Per-channel sequence loss pulse |
| ovf_pulse | output | 4 | Per-channel device overflow pulse |

## Verification
The bench targets the short final slice. A design that emitted three bytes there would give 189-byte packets with a misplaced end marker. It also targets a non-start word arriving on an idle channel: a faulty design would emit stray bytes, or would fail to record that word's count and then raise a false loss on the next word. A start flag in the middle of a packet must restart the count. Without that restart, the end marker would land mid-packet. Interleaved channels under a stalling consumer are checked byte for byte, because a shared position counter or a byte index that advanced without a handshake would scramble the payload. Words with a bad tag and the first word after reset must both stay silent.

// File: rtl/ts_slice_reassembler.sv
module ts_slice_reassembler #(
  parameter int NCH    = 4,
  parameter int SLICES = 63,
  parameter int SEQW   = 3
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     in_valid,
  output logic                     in_ready,
  input  logic [31:0]              in_word,
  output logic                     out_valid,
  input  logic                     out_ready,
  output logic [$clog2(NCH)-1:0]   out_chan,
  output logic [7:0]               out_byte,
  output logic                     out_sop,
  output logic                     out_eop,
  output logic [NCH-1:0]           loss_pulse,
  output logic [NCH-1:0]           ovf_pulse
);
  localparam int CW = $clog2(NCH);
  localparam int PW = $clog2(SLICES);
  localparam logic [PW-1:0] LAST = PW'(SLICES - 1);

  logic [PW-1:0]   pos      [NCH];
  logic [SEQW-1:0] seq_prev [NCH];
  logic [NCH-1:0]  seq_seen;

  logic            busy, h_first, h_last;
  logic [1:0]      h_idx;
  logic [23:0]     h_data;
  logic [CW-1:0]   h_chan;

  wire [2:0]      tag     = in_word[31:29];
  wire [SEQW-1:0] seq_in  = in_word[26 +: SEQW];
  wire            start   = in_word[25];
  wire            dev_ovf = in_word[24];
  wire            tag_ok  = (tag != 3'd0) && (int'(tag) <= NCH);
  wire [CW-1:0]   ch      = CW'(tag - 3'd1);
  wire            accept  = in_valid && in_ready;
  wire [PW-1:0]   slot    = start ? '0 : pos[ch];
  wire            emit    = tag_ok && (start || pos[ch] != '0);
  wire            seq_bad = seq_seen[ch] && (seq_in != SEQW'(seq_prev[ch] + SEQW'(1)));
  wire            drained = (h_idx == 2'd2) || (h_last && h_idx == 2'd1);

  assign in_ready  = !busy;
  assign out_valid = busy;
  assign out_chan  = h_chan;
  assign out_sop   = busy && h_first && h_idx == 2'd0;
  assign out_eop   = busy && h_last && h_idx == 2'd1;

  always_comb begin
    case (h_idx)
      2'd0:    out_byte = h_data[23:16];
      2'd1:    out_byte = h_data[15:8];
      default: out_byte = h_data[7:0];
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NCH; i++) begin
        pos[i]      <= '0;
        seq_prev[i] <= '0;
      end
      seq_seen   <= '0;
      loss_pulse <= '0;
      ovf_pulse  <= '0;
    end else begin
      loss_pulse <= '0;
      ovf_pulse  <= '0;
      if (accept && tag_ok) begin
        seq_prev[ch]   <= seq_in;
        seq_seen[ch]   <= 1'b1;
        loss_pulse[ch] <= seq_bad;
        ovf_pulse[ch]  <= dev_ovf;
        if (emit) pos[ch] <= (slot == LAST) ? '0 : slot + PW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      h_first <= 1'b0;
      h_last  <= 1'b0;
      h_idx   <= '0;
      h_data  <= '0;
      h_chan  <= '0;
    end else if (accept && emit) begin
      busy    <= 1'b1;
      h_first <= (slot == '0);
      h_last  <= (slot == LAST);
      h_idx   <= '0;
      h_data  <= in_word[23:0];
      h_chan  <= ch;
    end else if (busy && out_ready) begin
      if (drained) busy <= 1'b0;
      else h_idx <= h_idx + 2'd1;
    end
  end
endmodule

// File: rtl/ts_slice_reassembler_chk.sv
module ts_slice_reassembler_chk #(
  parameter int NCH = 4
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   in_valid,
  input logic                   in_ready,
  input logic [31:0]            in_word,
  input logic                   out_valid,
  input logic                   out_ready,
  input logic [$clog2(NCH)-1:0] out_chan,
  input logic [7:0]             out_byte,
  input logic                   out_sop,
  input logic                   out_eop,
  input logic [NCH-1:0]         loss_pulse,
  input logic [NCH-1:0]         ovf_pulse
);
  p_hold_stable_r10: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_byte) && $stable(out_chan)
                                && $stable(out_sop) && $stable(out_eop));

  p_backpressure_r10: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !in_ready);

  p_loss_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (loss_pulse != '0) |-> $past(in_valid && in_ready));

  p_loss_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(loss_pulse));

  p_ovf_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_pulse != '0) |-> $past(in_valid && in_ready && in_word[24]));

  p_ovf_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ovf_pulse));

  p_marker_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !(out_sop && out_eop));

  p_bad_tag_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && (in_word[31:29] == 3'd0)
    |=> !out_valid && loss_pulse == '0 && ovf_pulse == '0);
endmodule

bind ts_slice_reassembler ts_slice_reassembler_chk #(.NCH(NCH)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .in_word(in_word), .out_valid(out_valid), .out_ready(out_ready),
  .out_chan(out_chan), .out_byte(out_byte), .out_sop(out_sop),
  .out_eop(out_eop), .loss_pulse(loss_pulse), .ovf_pulse(ovf_pulse)
);

// File: tb/ts_slice_reassembler_bench.sv
`timescale 1ns/1ps
module ts_slice_reassembler_bench;
  logic clk = 0, rst_n = 0;
  logic in_valid = 0, out_ready = 1;
  logic [31:0] in_word = '0;
  logic in_ready, out_valid, out_sop, out_eop;
  logic [1:0] out_chan;
  logic [7:0] out_byte;
  logic [3:0] loss_pulse, ovf_pulse;

  ts_slice_reassembler u_ts_slice_reassembler (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_word(in_word), .out_valid(out_valid), .out_ready(out_ready),
    .out_chan(out_chan), .out_byte(out_byte), .out_sop(out_sop),
    .out_eop(out_eop), .loss_pulse(loss_pulse), .ovf_pulse(ovf_pulse));

  always #5 clk = ~clk;

  int vectors = 0, miscompares = 0, cyc = 0;
  int rec_n = 0;
  logic [7:0] rec_byte [4096];
  logic [1:0] rec_chan [4096];
  logic       rec_sop  [4096];
  logic       rec_eop  [4096];
  logic [3:0] got_loss, got_ovf;
  logic [2:0] bseq [4];
  bit stall_mode = 0;

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      miscompares++;
      $display("FAIL R10 watchdog: actual %0d cycles, expected fewer", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  always @(posedge clk) begin
    #2 out_ready = stall_mode ? (cyc % 3 == 0) : 1'b1;
  end

  always @(negedge clk) begin
    if (rst_n && out_valid && out_ready && rec_n < 4096) begin
      rec_byte[rec_n] = out_byte;
      rec_chan[rec_n] = out_chan;
      rec_sop[rec_n]  = out_sop;
      rec_eop[rec_n]  = out_eop;
      rec_n++;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(int ch, bit st, logic [2:0] sq, bit ov, int s);
    return {3'(ch + 1), sq, st, ov, 8'(s), 8'h80 | 8'(ch), ~8'(s)};
  endfunction

  function automatic logic [7:0] exp_byte(int ch, int k);
    int s = k / 3;
    case (k % 3)
      0: return 8'(s);
      1: return 8'h80 | 8'(ch);
      default: return ~8'(s);
    endcase
  endfunction

  task automatic send(input logic [31:0] w);
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    in_valid = 1; in_word = w;
    @(posedge clk);
    #1;
    got_loss = loss_pulse; got_ovf = ovf_pulse;
    in_valid = 0;
  endtask

  task automatic send_slice(input int ch, input bit st, input int s);
    send(mk(ch, st, bseq[ch], 0, s));
    bseq[ch] = bseq[ch] + 3'd1;
  endtask

  task automatic settle();
    repeat (8) @(negedge clk);
    while (out_valid) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic check_pkt(input int ch, input int skip, input string req);
    int n = 0, errs = 0;
    for (int i = 0; i < rec_n; i++) begin
      if (rec_chan[i] == 2'(ch)) begin
        if (n >= skip) begin
          int k = n - skip;
          if (rec_byte[i] !== exp_byte(ch, k) || rec_sop[i] !== (k == 0) ||
              rec_eop[i] !== (k == 187)) begin
            if (errs == 0)
              $display("FAIL %s: ch%0d byte %0d actual %0h/sop%0b/eop%0b expected %0h",
                       req, ch, k, rec_byte[i], rec_sop[i], rec_eop[i], exp_byte(ch, k));
            errs++;
          end
        end
        n++;
      end
    end
    chk(errs == 0, req, errs, 0);
    chk(n - skip == 188, req, n - skip, 188);
  endtask

  task automatic t_reset();
    chk(in_ready === 1'b1 && out_valid === 1'b0, "R10 reset ready/valid", int'(out_valid), 0);
    chk(loss_pulse === 4'd0 && ovf_pulse === 4'd0, "R7 reset pulses", int'(loss_pulse), 0);
  endtask

  task automatic t_first_unchecked();
    bit any_loss = 0;
    rec_n = 0;
    bseq[2] = 3'd3;
    send_slice(2, 1, 0);
    chk(got_loss == 4'd0, "R8 first word unchecked", int'(got_loss), 0);
    for (int s = 1; s < 63; s++) begin
      send_slice(2, 0, s);
      if (got_loss != 0) any_loss = 1;
    end
    settle();
    chk(!any_loss, "R7 in-order counts raise no loss", int'(any_loss), 0);
    check_pkt(2, 0, "R4 R5 R6 packet on ch2");
  endtask

  task automatic t_full_ch0();
    rec_n = 0;
    bseq[0] = 3'd6;
    for (int s = 0; s < 63; s++) send_slice(0, s == 0, s);
    settle();
    check_pkt(0, 0, "R1 R5 packet on ch0");
    chk(rec_n == 188, "R5 slice 62 gives two bytes", rec_n, 188);
  endtask

  task automatic t_drop_and_restart();
    rec_n = 0;
    send(mk(1, 0, 3'd5, 0, 9));
    settle();
    chk(rec_n == 0, "R3 non-start word on idle channel", rec_n, 0);
    send(mk(1, 1, 3'd6, 0, 0));
    chk(got_loss == 4'd0, "R7 count of dropped word recorded", int'(got_loss), 0);
    send(mk(1, 0, 3'd0, 0, 1));
    chk(got_loss == 4'b0010, "R7 skipped count flags loss", int'(got_loss), 2);
    bseq[1] = 3'd1;
    for (int s = 0; s < 63; s++) send_slice(1, s == 0, s);
    settle();
    chk(rec_n == 194, "R2 partial plus restarted packet", rec_n, 194);
    chk(rec_sop[0] && rec_sop[6] && !rec_eop[5], "R2 restart markers",
        int'({rec_sop[0], rec_sop[6], rec_eop[5]}), 6);
    check_pkt(1, 6, "R2 restarted packet intact");
  endtask

  task automatic t_bad_tag();
    bit noisy = 0;
    rec_n = 0;
    for (int t = 0; t < 8; t++) begin
      if (t >= 1 && t <= 4) continue;
      send({3'(t), 3'd2, 1'b1, 1'b1, 24'hABCDEF});
      if (got_loss != 0 || got_ovf != 0) noisy = 1;
    end
    settle();
    chk(rec_n == 0, "R1 bad tags emit nothing", rec_n, 0);
    chk(!noisy, "R1 bad tags raise no pulse", int'(noisy), 0);
  endtask

  task automatic t_overflow();
    rec_n = 0;
    bseq[3] = 3'd0;
    send(mk(3, 1, bseq[3], 1, 0));
    bseq[3] = bseq[3] + 3'd1;
    chk(got_ovf == 4'b1000, "R9 overflow pulse on ch3", int'(got_ovf), 8);
    send_slice(3, 0, 1);
    chk(got_ovf == 4'd0, "R9 pulse lasts one word", int'(got_ovf), 0);
    settle();
  endtask

  task automatic t_interleave_stall();
    rec_n = 0;
    stall_mode = 1;
    for (int s = 0; s < 63; s++) begin
      send_slice(2, s == 0, s);
      send_slice(3, s == 0, s);
    end
    settle();
    stall_mode = 0;
    settle();
    chk(rec_n == 376, "R10 no byte lost under stall", rec_n, 376);
    check_pkt(2, 0, "R11 interleaved ch2");
    check_pkt(3, 0, "R11 interleaved ch3");
  endtask

  initial begin
    for (int i = 0; i < 4; i++) bseq[i] = 3'd0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    repeat (2) @(negedge clk);
    t_first_unchecked();
    t_full_ch0();
    t_drop_and_restart();
    t_bad_tag();
    t_overflow();
    t_interleave_stall();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule